// File: doc/BRIEF.md
# Coprocessor Lockstep Channel

This block sits between a scalar host pipeline and a small number of tightly coupled coprocessors and keeps all of them moving in step. In each cycle the host may present one transaction: a valid flag, a coprocessor number, a 20-bit opcode word and a 32-bit write value. The channel decodes the opcode into one of three kinds. A data operation is forwarded to the selected coprocessor's datapath. A host-to-coprocessor register move captures the write value. A coprocessor-to-host register read fetches a word back to the host.

Reads normally return in the next cycle. If the selected datapath cannot supply the word at once, the channel lowers that coprocessor's active-low hold. The holds of all coprocessors are merged into one host stall, and the host stays frozen until the word arrives. While frozen, no coprocessor accepts a new opcode and the outstanding read keeps its register index. The host-side result is taken from whichever coprocessor the pending read was aimed at.

Top module: `cop_lockstep_if`

## Requirements
- R1: After reset, `hst_holdn` and every `cop_holdn` bit are 1, while `hst_rvalid`, `dp_op_valid`, `dp_wr_en` and `dp_rd_req` are all 0.
- R2: An opcode is taken only by the coprocessor whose index equals `hst_sel`. Every other coprocessor shows no command strobe.
- R3: Opcode bits [19:18]=00 is a data operation. In the next cycle the target's `dp_op_valid` bit is 1, its `dp_cmd_func` slice equals opcode bits [17:4] and its `dp_cmd_reg` slice equals bits [3:0].
- R4: Opcode bits [19:18]=01 is a register write. In the next cycle the target's `dp_wr_en` bit is 1 and `dp_cmd_reg` equals bits [3:0]. `dp_wr_data` holds the `hst_din` value of the issue cycle, even if `hst_din` changes afterwards.
- R5: Opcode bits [19:18]=10 is a register read. The target's `dp_rd_req` bit and `dp_rd_reg` slice are driven in the issue cycle. If the target's `dp_ready` is 1 in that cycle, `hst_rvalid` is 1 in the next cycle with `hst_rdata` equal to the supplied word, and `hst_holdn` stays 1.
- R6: If the datapath is not ready for a read, that coprocessor's hold is 0 from the next cycle onward. In the cycle after `dp_ready` rises, hold returns to 1 in the same cycle that `hst_rvalid` is 1 with the word.
- R7: While `hst_holdn` is 0, no opcode is accepted. The pending read keeps `dp_rd_req` high with an unchanged `dp_rd_reg`.
- R8: `hst_holdn` is 0 whenever any `cop_holdn` bit is 0. `cop_holdn` identifies the stalling coprocessor.
- R9: `hst_rdata` comes from the coprocessor selected by the most recent accepted read. A read to coprocessor 1 issued right after a stalled read to coprocessor 0 clears returns coprocessor 1's word in the next cycle.
- R10: Transactions may issue on consecutive cycles: a data operation, a write and a read back to back each produce their own result one cycle after issue.
- R11: Opcode bits [19:18]=11 is reserved and produces no strobe, no read request and no result.
- R12: With `hst_valid` at 0, the opcode is ignored: no strobe, no read request, no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_valid | input | 1 | Host transaction valid |
| hst_sel | input | SEL_W | Target coprocessor number |
| hst_opc | input | OPC_W | Opcode: kind [19:18], function [17:4], register [3:0] |
| hst_din | input | DATA_W | Host write value |
| hst_holdn | output | 1 | Merged active-low host stall |
| hst_rdata | output | DATA_W | Read word returned to host |
| hst_rvalid | output | 1 | Read word valid |
| dp_rd_req | output | NCOP | Per-coprocessor register read request |
| dp_rd_reg | output | NCOP*REG_W | Per-coprocessor read register index |
| dp_ready | input | NCOP | Datapath can supply the requested word this cycle |
| dp_rdata | input | NCOP*DATA_W | Per-coprocessor register read word |
| dp_op_valid | output | NCOP | Data operation strobe |
| dp_wr_en | output | NCOP | Register write strobe |
| dp_cmd_func | output | NCOP*FUNC_W | Function field of accepted command |
| dp_cmd_reg | output | NCOP*REG_W | Register field of accepted command |
| dp_wr_data | output | NCOP*DATA_W | Captured write value |
| cop_dout | output | NCOP*DATA_W | Per-coprocessor result register |
| cop_holdn | output | NCOP | Per-coprocessor active-low hold |

## Verification
Single transactions of each opcode kind are sent to each coprocessor. This separates correct target decoding from leakage into the neighbour, and correct field extraction from swapped fields. Reads are run with the datapath ready and with it held off for two cycles. That contrast shows whether the hold is raised, held and released in the right cycles, and whether a frozen host's opcode is wrongly accepted. A back-to-back sequence of operation, write and read checks the pipelining. A read to the second coprocessor right after a stalled read to the first shows whether the host result follows the registered select. Reserved opcodes and invalid cycles confirm that nothing leaks out when it should not.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
  typedef enum logic [1:0] {
    K_DOP  = 2'b00,
    K_WR   = 2'b01,
    K_RD   = 2'b10,
    K_NONE = 2'b11
  } cop_kind_e;
endpackage

// File: rtl/cpl_decode.sv
module cpl_decode
  import cpl_pkg::*;
#(
  parameter int OPC_W  = 20,
  parameter int REG_W  = 4,
  localparam int FUNC_W = OPC_W - 2 - REG_W
) (
  input  logic [OPC_W-1:0]  opc,
  output cop_kind_e         kind,
  output logic [FUNC_W-1:0] func,
  output logic [REG_W-1:0]  regi
);
  // kind in the top two bits, function in the middle, register at the bottom
  assign kind = cop_kind_e'(opc[OPC_W-1 -: 2]);
  assign func = opc[OPC_W-3 -: FUNC_W];
  assign regi = opc[REG_W-1:0];
endmodule

// File: rtl/cpl_port.sv
module cpl_port
  import cpl_pkg::*;
#(
  parameter int ID     = 0,
  parameter int SEL_W  = 1,
  parameter int DATA_W = 32,
  parameter int FUNC_W = 14,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [SEL_W-1:0]  sel,
  input  cop_kind_e         kind,
  input  logic [FUNC_W-1:0] func,
  input  logic [REG_W-1:0]  regi,
  input  logic [DATA_W-1:0] din,
  input  logic              dp_ready,
  input  logic [DATA_W-1:0] dp_rdata,
  output logic              rd_req,
  output logic [REG_W-1:0]  rd_reg,
  output logic              op_valid,
  output logic              wr_en,
  output logic [FUNC_W-1:0] cmd_func,
  output logic [REG_W-1:0]  cmd_reg,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid,
  output logic              holdn
);
  localparam logic [SEL_W-1:0] MY_ID = SEL_W'(ID);

  logic              hit, new_rd;
  logic              pend_q;
  logic [REG_W-1:0]  pend_reg_q;
  logic              op_valid_q, wr_en_q, dvalid_q, holdn_q;
  logic [FUNC_W-1:0] cmd_func_q;
  logic [REG_W-1:0]  cmd_reg_q;
  logic [DATA_W-1:0] wr_data_q, dout_q;

  assign hit    = issue && (sel == MY_ID);
  assign new_rd = hit && (kind == K_RD);
  assign rd_req = new_rd || pend_q;
  assign rd_reg = new_rd ? regi : pend_reg_q;

  // command capture toward the datapath
  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid_q <= 1'b0;
      wr_en_q    <= 1'b0;
      cmd_func_q <= '0;
      cmd_reg_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      op_valid_q <= hit && (kind == K_DOP);
      wr_en_q    <= hit && (kind == K_WR);
      if (hit) begin
        cmd_func_q <= func;
        cmd_reg_q  <= regi;
      end
      if (hit && (kind == K_WR)) wr_data_q <= din;
    end
  end

  // read return and stall
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_reg_q <= '0;
      dout_q     <= '0;
      dvalid_q   <= 1'b0;
      holdn_q    <= 1'b1;
    end else if (rd_req) begin
      if (dp_ready) begin
        dout_q   <= dp_rdata;
        dvalid_q <= 1'b1;
        pend_q   <= 1'b0;
        holdn_q  <= 1'b1;
      end else begin
        pend_q     <= 1'b1;
        pend_reg_q <= rd_reg;
        dvalid_q   <= 1'b0;
        holdn_q    <= 1'b0;
      end
    end else begin
      dvalid_q <= 1'b0;
      holdn_q  <= 1'b1;
    end
  end

  assign op_valid = op_valid_q;
  assign wr_en    = wr_en_q;
  assign cmd_func = cmd_func_q;
  assign cmd_reg  = cmd_reg_q;
  assign wr_data  = wr_data_q;
  assign dout     = dout_q;
  assign dvalid   = dvalid_q;
  assign holdn    = holdn_q;
endmodule

// File: rtl/cpl_merge.sv
module cpl_merge #(
  parameter int NCOP   = 2,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCOP-1:0]        holdn_vec,
  input  logic [NCOP-1:0]        dvalid_vec,
  input  logic [NCOP*DATA_W-1:0] dout_flat,
  input  logic                   rd_issue,
  input  logic [SEL_W-1:0]       rd_sel,
  output logic                   host_holdn,
  output logic [DATA_W-1:0]      host_rdata,
  output logic                   host_rvalid
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)           sel_q <= '0;
    else if (rd_issue) sel_q <= rd_sel;
  end

  assign host_holdn  = &holdn_vec;
  assign host_rvalid = |dvalid_vec;

  always_comb begin
    host_rdata = '0;
    for (int i = 0; i < NCOP; i++) begin
      if (sel_q == SEL_W'(i)) host_rdata = dout_flat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cop_lockstep_if.sv
module cop_lockstep_if
  import cpl_pkg::*;
#(
  parameter int NCOP   = 2,
  parameter int OPC_W  = 20,
  parameter int DATA_W = 32,
  parameter int REG_W  = 4,
  localparam int SEL_W  = (NCOP > 1) ? $clog2(NCOP) : 1,
  localparam int FUNC_W = OPC_W - 2 - REG_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hst_valid,
  input  logic [SEL_W-1:0]       hst_sel,
  input  logic [OPC_W-1:0]       hst_opc,
  input  logic [DATA_W-1:0]      hst_din,
  output logic                   hst_holdn,
  output logic [DATA_W-1:0]      hst_rdata,
  output logic                   hst_rvalid,
  output logic [NCOP-1:0]        dp_rd_req,
  output logic [NCOP*REG_W-1:0]  dp_rd_reg,
  input  logic [NCOP-1:0]        dp_ready,
  input  logic [NCOP*DATA_W-1:0] dp_rdata,
  output logic [NCOP-1:0]        dp_op_valid,
  output logic [NCOP-1:0]        dp_wr_en,
  output logic [NCOP*FUNC_W-1:0] dp_cmd_func,
  output logic [NCOP*REG_W-1:0]  dp_cmd_reg,
  output logic [NCOP*DATA_W-1:0] dp_wr_data,
  output logic [NCOP*DATA_W-1:0] cop_dout,
  output logic [NCOP-1:0]        cop_holdn
);
  cop_kind_e         kind;
  logic [FUNC_W-1:0] func;
  logic [REG_W-1:0]  regi;
  logic              issue, rd_issue;
  logic [NCOP-1:0]   dvalid_vec;

  cpl_decode #(.OPC_W(OPC_W), .REG_W(REG_W)) u_dec (
    .opc(hst_opc), .kind(kind), .func(func), .regi(regi)
  );

  // a frozen host may present an opcode, but nothing takes it
  assign issue    = hst_valid && hst_holdn && !rst;
  assign rd_issue = issue && (kind == K_RD) && (int'(hst_sel) < NCOP);

  for (genvar g = 0; g < NCOP; g++) begin : g_port
    cpl_port #(
      .ID(g), .SEL_W(SEL_W), .DATA_W(DATA_W), .FUNC_W(FUNC_W), .REG_W(REG_W)
    ) u_port (
      .clk      (clk),
      .rst      (rst),
      .issue    (issue),
      .sel      (hst_sel),
      .kind     (kind),
      .func     (func),
      .regi     (regi),
      .din      (hst_din),
      .dp_ready (dp_ready[g]),
      .dp_rdata (dp_rdata[g*DATA_W +: DATA_W]),
      .rd_req   (dp_rd_req[g]),
      .rd_reg   (dp_rd_reg[g*REG_W +: REG_W]),
      .op_valid (dp_op_valid[g]),
      .wr_en    (dp_wr_en[g]),
      .cmd_func (dp_cmd_func[g*FUNC_W +: FUNC_W]),
      .cmd_reg  (dp_cmd_reg[g*REG_W +: REG_W]),
      .wr_data  (dp_wr_data[g*DATA_W +: DATA_W]),
      .dout     (cop_dout[g*DATA_W +: DATA_W]),
      .dvalid   (dvalid_vec[g]),
      .holdn    (cop_holdn[g])
    );
  end

  cpl_merge #(.NCOP(NCOP), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_merge (
    .clk         (clk),
    .rst         (rst),
    .holdn_vec   (cop_holdn),
    .dvalid_vec  (dvalid_vec),
    .dout_flat   (cop_dout),
    .rd_issue    (rd_issue),
    .rd_sel      (hst_sel),
    .host_holdn  (hst_holdn),
    .host_rdata  (hst_rdata),
    .host_rvalid (hst_rvalid)
  );
endmodule

// File: rtl/cpl_chk.sv
module cpl_chk #(
  parameter int NCOP  = 2,
  parameter int REG_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  hst_holdn,
  input logic                  hst_rvalid,
  input logic [NCOP-1:0]       dp_rd_req,
  input logic [NCOP*REG_W-1:0] dp_rd_reg,
  input logic [NCOP-1:0]       dp_ready,
  input logic [NCOP-1:0]       dp_op_valid,
  input logic [NCOP-1:0]       dp_wr_en
);
  assert_single_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dp_op_valid | dp_wr_en));

  assert_ready_read_R5: assert property (@(posedge clk) disable iff (rst)
    (|(dp_rd_req & dp_ready)) |=> hst_rvalid);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (|(dp_rd_req & ~dp_ready)) |=> !hst_holdn);

  assert_release_data_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hst_holdn) |-> hst_rvalid);

  assert_frozen_no_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    !hst_holdn |=> (dp_op_valid == '0) && (dp_wr_en == '0));

  assert_frozen_req_R7: assert property (@(posedge clk) disable iff (rst)
    !hst_holdn |-> (dp_rd_req != '0));

  assert_pend_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!hst_holdn && $past(!hst_holdn)) |-> $stable(dp_rd_reg));
endmodule

bind cop_lockstep_if cpl_chk #(.NCOP(NCOP), .REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hst_holdn   (hst_holdn),
  .hst_rvalid  (hst_rvalid),
  .dp_rd_req   (dp_rd_req),
  .dp_rd_reg   (dp_rd_reg),
  .dp_ready    (dp_ready),
  .dp_op_valid (dp_op_valid),
  .dp_wr_en    (dp_wr_en)
);

// File: tb/tb_cop_lockstep_if.sv
module tb_cop_lockstep_if;
  localparam int NCOP = 2, OPC_W = 20, DW = 32, RW = 4, SW = 1;
  localparam int FW = OPC_W - 2 - RW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hst_valid = 1'b0;
  logic [SW-1:0] hst_sel = '0;
  logic [OPC_W-1:0] hst_opc = '0;
  logic [DW-1:0] hst_din = '0;
  logic hst_holdn, hst_rvalid;
  logic [DW-1:0] hst_rdata;
  logic [NCOP-1:0] dp_rd_req, dp_op_valid, dp_wr_en, cop_holdn;
  logic [NCOP-1:0] dp_ready = '1;
  logic [NCOP*RW-1:0] dp_rd_reg, dp_cmd_reg;
  logic [NCOP*FW-1:0] dp_cmd_func;
  logic [NCOP*DW-1:0] dp_rdata, dp_wr_data, cop_dout;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] word_of(int c, logic [RW-1:0] r);
    return 32'hC0DE_0000 + DW'(c) * 32'h100 + DW'(r);
  endfunction

  for (genvar g = 0; g < NCOP; g++) begin : g_dp
    assign dp_rdata[g*DW +: DW] = word_of(g, dp_rd_reg[g*RW +: RW]);
  end

  cop_lockstep_if dut (.*);

  function automatic logic [OPC_W-1:0] mk(logic [1:0] k, logic [FW-1:0] f, logic [RW-1:0] r);
    return {k, f, r};
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, int s, logic [OPC_W-1:0] o, logic [DW-1:0] d);
    hst_valid = v; hst_sel = SW'(s); hst_opc = o; hst_din = d;
  endtask

  task automatic idle();
    drive(1'b0, 0, '0, '0);
  endtask

  task automatic t_reset();
    check("R1 holdn", DW'(hst_holdn), 1);
    check("R1 cop_holdn", DW'(cop_holdn), 3);
    check("R1 rvalid", DW'(hst_rvalid), 0);
    check("R1 strobes", DW'({dp_op_valid, dp_wr_en, dp_rd_req}), 0);
  endtask

  task automatic t_dataop();
    @(negedge clk); drive(1'b1, 1, mk(2'b00, 14'h2A5, 4'd7), 32'h0);
    @(negedge clk); idle();
    check("R3 op_valid (R2 only cop1)", DW'(dp_op_valid), 2);
    check("R3 func", DW'(dp_cmd_func[FW +: FW]), 32'h2A5);
    check("R3 reg", DW'(dp_cmd_reg[RW +: RW]), 7);
    check("R2 no write", DW'(dp_wr_en), 0);
  endtask

  task automatic t_write();
    @(negedge clk); drive(1'b1, 0, mk(2'b01, 14'h0, 4'd3), 32'hDEAD_BEEF);
    @(negedge clk); drive(1'b0, 0, '0, 32'h1234_5678);
    check("R4 wr_en", DW'(dp_wr_en), 1);
    check("R4 reg", DW'(dp_cmd_reg[0 +: RW]), 3);
    check("R4 data", dp_wr_data[0 +: DW], 32'hDEAD_BEEF);
    idle();
  endtask

  task automatic t_read_fast();
    dp_ready = 2'b11;
    @(negedge clk); drive(1'b1, 0, mk(2'b10, 14'h0, 4'd5), 0);
    #1 check("R5 rd_req", DW'(dp_rd_req), 1);
    check("R5 rd_reg", DW'(dp_rd_reg[0 +: RW]), 5);
    @(negedge clk); idle();
    check("R5 rvalid", DW'(hst_rvalid), 1);
    check("R5 rdata", hst_rdata, word_of(0, 4'd5));
    check("R5 holdn", DW'(hst_holdn), 1);
  endtask

  task automatic t_stall();
    @(negedge clk); dp_ready = 2'b10; drive(1'b1, 0, mk(2'b10, 14'h0, 4'd9), 0);
    @(negedge clk);
    check("R6 holdn low", DW'(hst_holdn), 0);
    check("R8 cop_holdn", DW'(cop_holdn), 2);
    check("R6 no early data", DW'(hst_rvalid), 0);
    drive(1'b1, 1, mk(2'b00, 14'h11, 4'd1), 0);
    #1 check("R7 pending req", DW'(dp_rd_req), 1);
    check("R7 pending reg", DW'(dp_rd_reg[0 +: RW]), 9);
    @(negedge clk);
    check("R7 still held", DW'(hst_holdn), 0);
    check("R7 no op taken", DW'(dp_op_valid), 0);
    dp_ready = 2'b11;
    @(negedge clk);
    check("R6 released", DW'(hst_holdn), 1);
    check("R6 rvalid", DW'(hst_rvalid), 1);
    check("R6 rdata", hst_rdata, word_of(0, 4'd9));
    check("R7 frozen op dropped", DW'(dp_op_valid), 0);
    drive(1'b1, 1, mk(2'b10, 14'h0, 4'd2), 0);
    @(negedge clk); idle();
    check("R9 rvalid", DW'(hst_rvalid), 1);
    check("R9 rdata cop1", hst_rdata, word_of(1, 4'd2));
    dp_ready = 2'b01; drive(1'b1, 1, mk(2'b10, 14'h0, 4'd4), 0);
    @(negedge clk); idle();
    check("R8 cop1 stall", DW'(cop_holdn), 1);
    check("R8 host stall", DW'(hst_holdn), 0);
    dp_ready = 2'b11;
    @(negedge clk);
    check("R9 late cop1 rdata", hst_rdata, word_of(1, 4'd4));
    check("R8 released", DW'(hst_holdn), 1);
  endtask

  task automatic t_back2back();
    dp_ready = 2'b11;
    @(negedge clk); drive(1'b1, 0, mk(2'b00, 14'h3, 4'd6), 0);
    @(negedge clk); drive(1'b1, 1, mk(2'b01, 14'h0, 4'd8), 32'hA5A5_0001);
    check("R10 op", DW'(dp_op_valid), 1);
    check("R10 op func", DW'(dp_cmd_func[0 +: FW]), 3);
    @(negedge clk); drive(1'b1, 0, mk(2'b10, 14'h0, 4'd12), 0);
    check("R10 write", DW'(dp_wr_en), 2);
    check("R10 write data", dp_wr_data[DW +: DW], 32'hA5A5_0001);
    check("R10 op ended", DW'(dp_op_valid), 0);
    @(negedge clk); idle();
    check("R10 read data", hst_rdata, word_of(0, 4'd12));
    check("R10 read valid", DW'(hst_rvalid), 1);
  endtask

  task automatic t_ignored();
    @(negedge clk); drive(1'b1, 0, mk(2'b11, 14'h7, 4'd2), 0);
    #1 check("R11 no rd_req", DW'(dp_rd_req), 0);
    @(negedge clk); drive(1'b0, 1, mk(2'b10, 14'h0, 4'd3), 0);
    check("R11 no strobe", DW'({dp_op_valid, dp_wr_en}), 0);
    check("R11 no result", DW'(hst_rvalid), 0);
    #1 check("R12 no rd_req", DW'(dp_rd_req), 0);
    @(negedge clk); idle();
    check("R12 no result", DW'(hst_rvalid), 0);
    check("R12 no strobe", DW'({dp_op_valid, dp_wr_en}), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_dataop();
    t_write();
    t_read_fast();
    t_stall();
    t_back2back();
    t_ignored();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule